// File: doc/BRIEF.md
# Thread Block Dispatcher

This block takes one kernel launch at a time and hands its thread blocks out, one per cycle at most, to a fixed set of streaming multiprocessors. A launch states the block count, the threads per block, the registers each thread needs and the shared-memory bytes each block needs. Two of these are combined into a per-block demand when the launch is taken: registers are the per-thread count times the thread count, and shared memory is the per-block byte count. Each multiprocessor keeps running totals of resident blocks, threads, registers and shared bytes. A block goes to a multiprocessor only if every one of those totals stays within its cap after the block is added.

Dispatches leave on a valid/ready handshake that carries the block index and the chosen multiprocessor. A completion input names the multiprocessor where a block finished. The demand latched at launch is then returned to that multiprocessor's totals. Blocks that do not fit wait until completions free room, so a launch can be larger than what fits at once. A launch whose block shape can never fit is refused with an error flag. A kernel-done flag reports that every block has been issued and has retired.

Top module: `blk_dispatcher`

## Requirements
- R1: A multiprocessor is chosen only if, after adding the block, it holds at most 32 blocks, 2048 threads, 65536 registers and 49152 shared bytes (the default parameters).
- R2: A launch is refused if its threads per block are 0 or above 1024, or if its per-block register demand is above 65536, or if its shared bytes are above 49152. A refused launch sets launch_err from the next clock edge, dispatches nothing and leaves kernel_done low. The next accepted launch clears launch_err.
- R3: Blocks are issued in ascending order starting at index 0. The block index port is 31 bits wide.
- R4: disp_sm is the lowest-numbered multiprocessor that can admit the block. At most one block is handed over per cycle, on a cycle where disp_valid and disp_ready are both high.
- R5: If no multiprocessor can admit the next block, disp_valid stays low. The waiting block is offered again once completions free enough room.
- R6: A completion (cmpl_valid with cmpl_sm) frees that multiprocessor's resources in the same cycle, and that cycle's dispatch decision already sees the freed room.
- R7: kernel_done goes high at the clock edge that records the last completion, once every block has been issued. It is low while blocks are still outstanding. A launch of zero blocks sets it at the next edge.
- R8: launch_valid is ignored while a launch is still in progress.
- R9: The per-block demand is latched when the launch is accepted. Changes on the launch inputs afterwards have no effect.
- R10: While disp_valid is high and disp_ready is low, disp_blk holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | Launch request, taken when no launch is in progress |
| launch_blocks | input | 31 | Number of blocks in the launch |
| launch_threads | input | 16 | Threads per block |
| launch_regs_per_thread | input | 8 | Registers per thread |
| launch_smem | input | 17 | Shared-memory bytes per block |
| launch_err | output | 1 | The last launch presented while idle was refused |
| disp_valid | output | 1 | A block is offered for dispatch |
| disp_ready | input | 1 | The consumer takes the offered block |
| disp_blk | output | 31 | Index of the offered block |
| disp_sm | output | 2 | Multiprocessor chosen for the offered block |
| cmpl_valid | input | 1 | A resident block has finished |
| cmpl_sm | input | 2 | Multiprocessor on which that block finished |
| kernel_done | output | 1 | All blocks issued and retired |

## Verification
The dispatch outputs are combinational views of registered totals and the present completion. The bench therefore drives ready and completion half a clock before the edge, lets them settle, and compares disp_valid, disp_blk and disp_sm within that same cycle against a bench model of every multiprocessor's totals. Its model is updated only after the edge, in the order completion then dispatch. launch_err and kernel_done are registered, so they are due one edge after the launch or after the final completion. The bench compares them on the following cycle against model flags set at that edge.

// File: rtl/blk_disp_pkg.sv
`timescale 1ns/1ps
package blk_disp_pkg;
   localparam int unsigned NEED_W = 32;

   // per-block resource demand, fixed for one launch
   typedef struct packed {
      logic [NEED_W-1:0] thr;
      logic [NEED_W-1:0] regs;
      logic [NEED_W-1:0] smem;
   } blk_need_t;
endpackage

// File: rtl/blk_sm_ledger.sv
`timescale 1ns/1ps
module blk_sm_ledger
   import blk_disp_pkg::*;
#(
   parameter int MAX_BLK  = 32,
   parameter int MAX_THR  = 2048,
   parameter int MAX_REG  = 65536,
   parameter int MAX_SMEM = 49152
) (
   input  logic      clk,
   input  logic      rst_n,
   input  blk_need_t need,
   input  logic      take,
   input  logic      give,
   output logic      admit
);
   localparam int BW = $clog2(MAX_BLK + 1);
   localparam int TW = $clog2(MAX_THR + 1);
   localparam int RW = $clog2(MAX_REG + 1);
   localparam int SW = $clog2(MAX_SMEM + 1);
   localparam int XW = NEED_W + 1;

   logic [BW-1:0] n_blk;
   logic [TW-1:0] n_thr;
   logic [RW-1:0] n_reg;
   logic [SW-1:0] n_sm;
   logic          give_ok;
   logic [XW-1:0] a_blk, a_thr, a_reg, a_sm;
   logic [XW-1:0] x_blk, x_thr, x_reg, x_sm;

   assign give_ok = give && (n_blk != '0);

   always_comb begin
      a_blk = XW'(n_blk) - (give_ok ? XW'(1) : '0);
      a_thr = XW'(n_thr) - (give_ok ? XW'(need.thr) : '0);
      a_reg = XW'(n_reg) - (give_ok ? XW'(need.regs) : '0);
      a_sm  = XW'(n_sm)  - (give_ok ? XW'(need.smem) : '0);
      admit = (a_blk + XW'(1) <= XW'(MAX_BLK))
           && (a_thr + XW'(need.thr) <= XW'(MAX_THR))
           && (a_reg + XW'(need.regs) <= XW'(MAX_REG))
           && (a_sm  + XW'(need.smem) <= XW'(MAX_SMEM));
      x_blk = a_blk + (take ? XW'(1) : '0);
      x_thr = a_thr + (take ? XW'(need.thr) : '0);
      x_reg = a_reg + (take ? XW'(need.regs) : '0);
      x_sm  = a_sm  + (take ? XW'(need.smem) : '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_blk <= '0;
         n_thr <= '0;
         n_reg <= '0;
         n_sm  <= '0;
      end else begin
         n_blk <= BW'(x_blk);
         n_thr <= TW'(x_thr);
         n_reg <= RW'(x_reg);
         n_sm  <= SW'(x_sm);
      end
   end

   p_caps_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(n_blk) <= MAX_BLK) && (int'(n_thr) <= MAX_THR)
      && (int'(n_reg) <= MAX_REG) && (int'(n_sm) <= MAX_SMEM));
   p_take_fits_r1: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> admit);
   p_give_live_r6: assert property (@(posedge clk) disable iff (!rst_n)
      give |-> (n_blk != '0));
endmodule

// File: rtl/blk_low_pick.sv
`timescale 1ns/1ps
module blk_low_pick #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  gnt,
   output logic [IW-1:0] idx,
   output logic          any
);
   if (N == 1) begin : g_single
      assign gnt = req;
      assign idx = '0;
      assign any = req[0];
   end else begin : g_multi
      always_comb begin
         gnt = '0;
         idx = '0;
         any = 1'b0;
         for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
               gnt[i] = 1'b1;
               idx    = IW'(i);
               any    = 1'b1;
            end
         end
      end
   end

   p_gnt_one_r4: assert property (@(req) 1'b1 |-> $onehot0(gnt)) else ;
endmodule

// File: rtl/blk_launch_ctl.sv
`timescale 1ns/1ps
module blk_launch_ctl
   import blk_disp_pkg::*;
#(
   parameter int IDX_W       = 31,
   parameter int OUT_W       = 8,
   parameter int THR_IN_W    = 16,
   parameter int RPT_W       = 8,
   parameter int SMEM_IN_W   = 17,
   parameter int MAX_BLK_THR = 1024,
   parameter int MAX_REG     = 65536,
   parameter int MAX_SMEM    = 49152
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch_valid,
   input  logic [IDX_W-1:0]     blocks,
   input  logic [THR_IN_W-1:0]  threads,
   input  logic [RPT_W-1:0]     rpt,
   input  logic [SMEM_IN_W-1:0] smem,
   input  logic                 fire,
   input  logic                 give,
   output logic                 running,
   output blk_need_t            need,
   output logic [IDX_W-1:0]     next_idx,
   output logic                 has_more,
   output logic                 kernel_done,
   output logic                 launch_err
);
   logic [IDX_W-1:0]  total;
   logic [OUT_W-1:0]  outstanding;
   logic [IDX_W-1:0]  idx_nxt;
   logic [OUT_W-1:0]  out_nxt;
   logic [NEED_W-1:0] regs_req;
   logic              bad;

   assign regs_req = NEED_W'(rpt) * NEED_W'(threads);
   assign bad = (threads == '0)
             || (NEED_W'(threads) > NEED_W'(MAX_BLK_THR))
             || (regs_req > NEED_W'(MAX_REG))
             || (NEED_W'(smem) > NEED_W'(MAX_SMEM));
   assign idx_nxt  = next_idx + IDX_W'(fire);
   assign out_nxt  = outstanding + OUT_W'(fire) - OUT_W'(give);
   assign has_more = running && (next_idx != total);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running     <= 1'b0;
         kernel_done <= 1'b0;
         launch_err  <= 1'b0;
         next_idx    <= '0;
         total       <= '0;
         outstanding <= '0;
         need        <= '0;
      end else if (launch_valid && !running) begin
         launch_err  <= bad;
         next_idx    <= '0;
         total       <= blocks;
         outstanding <= '0;
         need.thr    <= NEED_W'(threads);
         need.regs   <= regs_req;
         need.smem   <= NEED_W'(smem);
         running     <= !bad && (blocks != '0);
         kernel_done <= !bad && (blocks == '0);
      end else if (running) begin
         next_idx    <= idx_nxt;
         outstanding <= out_nxt;
         if (idx_nxt == total && out_nxt == '0) begin
            running     <= 1'b0;
            kernel_done <= 1'b1;
         end
      end
   end

   p_give_owed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      give |-> (outstanding != '0));
   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kernel_done |-> !running);
   p_err_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      launch_err |-> !running);
endmodule

// File: rtl/blk_dispatcher.sv
`timescale 1ns/1ps
module blk_dispatcher
   import blk_disp_pkg::*;
#(
   parameter int NUM_SM      = 4,
   parameter int IDX_W       = 31,
   parameter int THR_IN_W    = 16,
   parameter int RPT_W       = 8,
   parameter int SMEM_IN_W   = 17,
   parameter int MAX_BLK     = 32,
   parameter int MAX_THR     = 2048,
   parameter int MAX_REG     = 65536,
   parameter int MAX_SMEM    = 49152,
   parameter int MAX_BLK_THR = 1024,
   localparam int SM_W = (NUM_SM > 1) ? $clog2(NUM_SM) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch_valid,
   input  logic [IDX_W-1:0]     launch_blocks,
   input  logic [THR_IN_W-1:0]  launch_threads,
   input  logic [RPT_W-1:0]     launch_regs_per_thread,
   input  logic [SMEM_IN_W-1:0] launch_smem,
   output logic                 launch_err,
   output logic                 disp_valid,
   input  logic                 disp_ready,
   output logic [IDX_W-1:0]     disp_blk,
   output logic [SM_W-1:0]      disp_sm,
   input  logic                 cmpl_valid,
   input  logic [SM_W-1:0]      cmpl_sm,
   output logic                 kernel_done
);
   localparam int OUT_W = $clog2(NUM_SM * MAX_BLK + 1);

   if (NUM_SM < 1 || IDX_W < 1) begin : g_bad_shape
      $error("blk_dispatcher: NUM_SM and IDX_W must be positive");
   end
   if (MAX_BLK_THR > MAX_THR) begin : g_bad_thr
      $error("blk_dispatcher: block thread cap above per-SM thread cap");
   end

   logic              running, has_more, fire, any_ok;
   blk_need_t         need;
   logic [NUM_SM-1:0] ok, gnt, take, give;

   blk_launch_ctl #(
      .IDX_W(IDX_W), .OUT_W(OUT_W), .THR_IN_W(THR_IN_W), .RPT_W(RPT_W),
      .SMEM_IN_W(SMEM_IN_W), .MAX_BLK_THR(MAX_BLK_THR),
      .MAX_REG(MAX_REG), .MAX_SMEM(MAX_SMEM)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid),
      .blocks(launch_blocks), .threads(launch_threads),
      .rpt(launch_regs_per_thread), .smem(launch_smem),
      .fire(fire), .give(cmpl_valid && running),
      .running(running), .need(need), .next_idx(disp_blk),
      .has_more(has_more), .kernel_done(kernel_done), .launch_err(launch_err)
   );

   for (genvar i = 0; i < NUM_SM; i++) begin : g_sm
      assign give[i] = cmpl_valid && running && (cmpl_sm == SM_W'(i));
      assign take[i] = fire && gnt[i];
      blk_sm_ledger #(
         .MAX_BLK(MAX_BLK), .MAX_THR(MAX_THR),
         .MAX_REG(MAX_REG), .MAX_SMEM(MAX_SMEM)
      ) u_ledger (
         .clk(clk), .rst_n(rst_n), .need(need),
         .take(take[i]), .give(give[i]), .admit(ok[i])
      );
   end

   blk_low_pick #(.N(NUM_SM)) u_pick (
      .req(ok), .gnt(gnt), .idx(disp_sm), .any(any_ok)
   );

   assign disp_valid = has_more && any_ok;
   assign fire       = disp_valid && disp_ready;

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && !disp_ready) |=> $stable(disp_blk));
   p_ascend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (disp_blk == $past(disp_blk) + IDX_W'(1)));
   p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      launch_err |-> !disp_valid);
   p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      kernel_done |-> !disp_valid);
   p_one_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(take));
endmodule

// File: tb/blk_dispatcher_tb.sv
`timescale 1ns/1ps
module blk_dispatcher_tb;
   localparam int NSM = 4;
   localparam int CB = 32, CT = 2048, CR = 65536, CS = 49152;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        launch_valid = 1'b0;
   logic [30:0] launch_blocks = '0;
   logic [15:0] launch_threads = '0;
   logic [7:0]  launch_regs_per_thread = '0;
   logic [16:0] launch_smem = '0;
   logic        launch_err, disp_valid, kernel_done;
   logic        disp_ready = 1'b0;
   logic [30:0] disp_blk;
   logic [1:0]  disp_sm;
   logic        cmpl_valid = 1'b0;
   logic [1:0]  cmpl_sm = '0;

   always #2.5 clk = ~clk;

   blk_dispatcher u_dut (
      .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid),
      .launch_blocks(launch_blocks), .launch_threads(launch_threads),
      .launch_regs_per_thread(launch_regs_per_thread), .launch_smem(launch_smem),
      .launch_err(launch_err), .disp_valid(disp_valid), .disp_ready(disp_ready),
      .disp_blk(disp_blk), .disp_sm(disp_sm), .cmpl_valid(cmpl_valid),
      .cmpl_sm(cmpl_sm), .kernel_done(kernel_done)
   );

   int m_blk[NSM], m_thr[NSM], m_reg[NSM], m_sm[NSM];
   int m_total = 0, m_next = 0, m_out = 0;
   bit m_run = 0, m_done = 0, m_err = 0;
   int d_thr = 0, d_reg = 0, d_sm = 0;
   int tests = 0, fails = 0;
   bit finished = 0;

   task automatic chk(string req, longint act, longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit fits(int s, int cs, bit cv);
      int b, t, r, m;
      b = m_blk[s]; t = m_thr[s]; r = m_reg[s]; m = m_sm[s];
      if (cv && cs == s) begin b -= 1; t -= d_thr; r -= d_reg; m -= d_sm; end
      return (b + 1 <= CB) && (t + d_thr <= CT) && (r + d_reg <= CR) && (m + d_sm <= CS);
   endfunction

   task automatic launch(int blocks, int thr, int rpt, int smem);
      bit bad;
      @(negedge clk);
      launch_valid = 1'b1;
      launch_blocks = 31'(blocks);
      launch_threads = 16'(thr);
      launch_regs_per_thread = 8'(rpt);
      launch_smem = 17'(smem);
      disp_ready = 1'b0;
      cmpl_valid = 1'b0;
      @(posedge clk);
      if (!m_run) begin  // R8: only taken when idle
         bad = (thr == 0) || (thr > 1024) || (rpt * thr > CR) || (smem > CS);
         m_err = bad;
         m_next = 0; m_out = 0; m_total = blocks;
         d_thr = thr; d_reg = rpt * thr; d_sm = smem;
         m_run = !bad && blocks != 0;
         m_done = !bad && blocks == 0;
      end
   endtask

   task automatic step(int p_rdy, int p_cmpl);
      bit cv, ev;
      int cs, es, st;
      @(negedge clk);
      launch_valid = 1'b0;
      // R9: launch inputs wander once the launch is latched
      launch_blocks = 31'($urandom);
      launch_threads = 16'($urandom);
      launch_regs_per_thread = 8'($urandom);
      launch_smem = 17'($urandom);
      disp_ready = (($urandom % 100) < p_rdy);
      cv = 0; cs = 0;
      if (m_out > 0 && ($urandom % 100) < p_cmpl) begin
         st = $urandom % NSM;
         for (int k = 0; k < NSM; k++) begin
            if (!cv && m_blk[(st + k) % NSM] > 0) begin cv = 1; cs = (st + k) % NSM; end
         end
      end
      cmpl_valid = cv;
      cmpl_sm = 2'(cs);
      #1;
      ev = 0; es = 0;
      if (m_run && m_next < m_total) begin
         for (int s = 0; s < NSM; s++) if (!ev && fits(s, cs, cv)) begin ev = 1; es = s; end
      end
      chk("R1 R5 R6 disp_valid", disp_valid, ev);
      if (ev && disp_valid) begin
         chk("R3 disp_blk", disp_blk, m_next);
         chk("R4 disp_sm", disp_sm, es);
      end
      chk("R7 kernel_done", kernel_done, m_done);
      chk("R2 launch_err", launch_err, m_err);
      @(posedge clk);
      if (cv) begin
         m_blk[cs] -= 1; m_thr[cs] -= d_thr; m_reg[cs] -= d_reg; m_sm[cs] -= d_sm; m_out--;
      end
      if (ev && disp_ready) begin
         m_blk[es] += 1; m_thr[es] += d_thr; m_reg[es] += d_reg; m_sm[es] += d_sm;
         m_next++; m_out++;
      end
      if (m_run && m_next == m_total && m_out == 0) begin m_run = 0; m_done = 1; end
   endtask

   task automatic drain();
      int guard = 0;
      while (m_run && guard < 20000) begin step(70, 45); guard++; end
      step(50, 0);
      chk("R7 drained", kernel_done, 1);
   endtask

   task automatic fill_then_drain(int blocks, int thr, int rpt, int smem, int stall_cap);
      launch(blocks, thr, rpt, smem);
      for (int c = 0; c < stall_cap + 20; c++) step(100, 0);
      chk("R1 R5 resident at stall", m_next, stall_cap);
      drain();
   endtask

   initial begin
      void'($urandom(32'd20417));
      for (int s = 0; s < NSM; s++) begin m_blk[s] = 0; m_thr[s] = 0; m_reg[s] = 0; m_sm[s] = 0; end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("reset disp_valid", disp_valid, 0);
      chk("reset kernel_done", kernel_done, 0);
      chk("reset launch_err", launch_err, 0);
      rst_n = 1'b1;
      step(100, 0);
      // R1 block cap: 4 x 32 resident
      fill_then_drain(150, 32, 0, 0, 128);
      // R1 thread cap: 2 per SM
      fill_then_drain(20, 1024, 2, 0, 8);
      // R1 register cap: 16384 per block, 4 per SM
      fill_then_drain(30, 256, 64, 0, 16);
      // R1 shared-memory cap: 2 per SM
      fill_then_drain(25, 64, 4, 20000, 8);
      // R2 refused launches
      launch(10, 1025, 0, 0);
      for (int c = 0; c < 4; c++) step(100, 0);
      chk("R2 no dispatch", m_next, 0);
      launch(10, 0, 0, 0);
      step(100, 0);
      launch(10, 64, 0, 50000);
      step(100, 0);
      launch(10, 1024, 128, 0);
      step(100, 0);
      // R7 zero-block launch
      launch(0, 64, 1, 0);
      step(100, 0);
      chk("R7 zero blocks done", kernel_done, 1);
      // R8 launch during a run is ignored
      launch(60, 128, 8, 1000);
      for (int c = 0; c < 10; c++) step(60, 30);
      launch(5, 1025, 0, 0);
      step(60, 30);
      chk("R8 err untouched", launch_err, 0);
      drain();
      // random launches
      for (int n = 0; n < 6; n++) begin
         launch(1 + $urandom % 80, 1 + $urandom % 1024, $urandom % 80, $urandom % 30000);
         if (m_run) drain(); else step(100, 0);
      end
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule